// File: doc/BRIEF.md
# Trim Register with Fifty-Slot Permanent Store

This block keeps a wiper code for a digital rheostat in a volatile register. It can also commit that code to a bank of fifty one-time-programmable slots. It takes 16-bit command frames that a serial slave front end has already deframed and presents them with a one-cycle valid strobe. The commands write or read the register, store it to the next free slot, force a restore, read back a chosen slot, and set the control bits. The bank is a behavioural slot array. A slot becomes permanent, and counts as used, only when its program window completes.

A write-enable control bit gates every change to the register and every store, and it is clear after any reset. When power is applied, and whenever the active-low reset input is released, the register reloads from the most recently programmed slot. If no slot has been programmed, it loads midscale. Each operation holds the busy flag high for a window given as a parameterised cycle count. The block ignores a command that arrives while it is busy, and it also ignores a command that comes too soon after the last accepted one.

Top module: `trim_store_ctrl`

## Requirements
- R1: A frame is accepted only when bits 15:14 are both 0. Bits 13:10 hold the control code. The data field starts at bit 9 and is DATA_W bits wide, left-aligned (bits 9:0 for 10 bits, bits 9:2 for 8 bits).
- R2: After `por_n` rises, the slot bank is blank and slots_used reads 0. Busy is high for exactly PWR_CYC clock edges, and the wiper then holds midscale (0x200 for 10 bits).
- R3: Code 0x7 loads the control bits from the frame: bit 0 is write enable and bit 1 is performance mode. Both bits are clear after `por_n` or `rst_n`. While write enable is clear, a write (0x1) or a store (0x3) leaves the wiper, busy and slots_used unchanged.
- R4: An accepted write (0x1) loads the data field into the wiper on the accepting edge. Busy is then high for WR_CYC edges, or for WRP_CYC edges in performance mode.
- R5: A read (0x2) places the wiper on rd_data and raises rd_valid on the accepting edge. Any later accepted command clears rd_valid.
- R6: A frame presented while busy is high is ignored. This includes a frame on the very edge where a window ends.
- R7: After a command is accepted at edge E, frames at edges E+1 to E+GAP_CYC-1 are ignored. A frame at E+GAP_CYC is accepted if the block is not busy.
- R8: A store (0x3) captures the wiper when it is accepted and holds busy high for PROG_CYC edges. The captured value is written to the next free slot, and slots_used goes up by one, on the edge where busy falls.
- R9: Once slots_used equals SLOTS, a store is refused: busy stays low and slots_used does not change.
- R10: A restore (0x4) holds busy high for RST_CYC edges. It then loads the wiper from the highest-numbered programmed slot, or midscale if no slot has been programmed.
- R11: While `rst_n` is low, and for RST_CYC edges after it rises, busy is high. The wiper then reloads as in R10. Slots already programmed are kept, and a program window cut short by the reset does not consume a slot.
- R12: A slot readback (0x5) takes its slot index from frame bits 5:0 and holds busy high for RDBK_CYC edges. It then presents that slot on rd_data with rd_valid high, or 0 for a slot that has not been programmed.
- R13: Codes 0x0, 0x6 and 0x8 to 0xF change neither the wiper, busy, slots_used nor the control bits.
- R14: slots_used never exceeds SLOTS and never rises by more than one per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; blanks the bank and starts the power-up restore |
| rst_n | input | 1 | Active-low synchronous reset; triggers a restore from the bank |
| cmd_valid | input | 1 | Frame strobe |
| cmd_frame | input | 16 | Deframed command word |
| wiper | output | DATA_W | Current wiper code |
| busy | output | 1 | Operation window in progress |
| slots_used | output | $clog2(SLOTS+1) | Number of programmed slots |
| rd_data | output | DATA_W | Readback word |
| rd_valid | output | 1 | rd_data holds a result |

## Verification
Two functions can fall in the same cycle: the end of a program window and a new command frame. The bench provokes this by holding a write frame valid up to and including the edge where the store completes. It then judges the outcome on the following cycle: slots_used must have advanced by one, busy must have fallen, and the wiper must be untouched by the late write. A second such clash puts a reset inside a running program window, and the bench confirms that no slot was consumed.

// File: rtl/trim_store_ctrl.sv
`timescale 1ns/1ps
module trim_store_ctrl #(
  parameter int DATA_W   = 10,
  parameter int SLOTS    = 50,
  parameter int PWR_CYC  = 400000,
  parameter int RST_CYC  = 120000,
  parameter int PROG_CYC = 70000000,
  parameter int RDBK_CYC = 1200,
  parameter int WR_CYC   = 120,
  parameter int WRP_CYC  = 400,
  parameter int GAP_CYC  = 100,
  localparam int UW      = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_frame,
  output logic [DATA_W-1:0] wiper,
  output logic              busy,
  output logic [UW-1:0]     slots_used,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int AW  = $clog2(SLOTS);
  localparam int M1  = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
  localparam int M2  = (PROG_CYC > RDBK_CYC) ? PROG_CYC : RDBK_CYC;
  localparam int M3  = (WR_CYC > WRP_CYC) ? WR_CYC : WRP_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M12 > M3) ? M12 : M3;
  localparam int TW  = $clog2(TMAX + 1);
  localparam int GW  = $clog2(GAP_CYC + 1);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [1:0] {OP_WR, OP_ST, OP_RS, OP_RB} op_t;

  logic [DATA_W-1:0] mem [SLOTS];
  logic [TW-1:0]     timer;
  logic [GW-1:0]     gap;
  op_t               op;
  logic              we, perf;
  logic [DATA_W-1:0] prog_d;
  logic [UW-1:0]     rb_a, last_i;

  wire [3:0]        code = cmd_frame[13:10];
  wire [DATA_W-1:0] din  = cmd_frame[9 -: DATA_W];
  wire acc  = cmd_valid && (cmd_frame[15:14] == 2'b00) && !busy && (gap == '0);
  wire done = (timer == TW'(1));

  assign busy   = (timer != '0);
  assign last_i = slots_used - 1'b1;
  wire [DATA_W-1:0] latest = (slots_used == '0) ? MID : mem[last_i[AW-1:0]];

  always_ff @(posedge clk)
    if (rst_n && done && op == OP_ST) mem[slots_used[AW-1:0]] <= prog_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wiper <= MID; slots_used <= '0; timer <= TW'(PWR_CYC); op <= OP_RS;
      we <= 1'b0; perf <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      gap <= '0; prog_d <= '0; rb_a <= '0;
    end else if (!rst_n) begin
      timer <= TW'(RST_CYC); op <= OP_RS;
      we <= 1'b0; perf <= 1'b0; rd_valid <= 1'b0; gap <= '0;
    end else begin
      if (gap != '0) gap <= gap - 1'b1;
      if (busy) timer <= timer - 1'b1;
      if (done) begin
        case (op)
          OP_RS: wiper <= latest;
          OP_ST: slots_used <= slots_used + 1'b1;
          OP_RB: begin
            rd_data  <= (rb_a < slots_used) ? mem[rb_a[AW-1:0]] : '0;
            rd_valid <= 1'b1;
          end
          default: ;
        endcase
      end
      if (acc) begin
        gap <= GW'(GAP_CYC - 1);
        rd_valid <= 1'b0;
        case (code)
          4'h1: if (we) begin
            wiper <= din; op <= OP_WR;
            timer <= perf ? TW'(WRP_CYC) : TW'(WR_CYC);
          end
          4'h2: begin rd_data <= wiper; rd_valid <= 1'b1; end
          4'h3: if (we && slots_used < UW'(SLOTS)) begin
            prog_d <= wiper; timer <= TW'(PROG_CYC); op <= OP_ST;
          end
          4'h4: begin timer <= TW'(RST_CYC); op <= OP_RS; end
          4'h5: begin
            rb_a <= UW'(cmd_frame[AW-1:0]); timer <= TW'(RDBK_CYC); op <= OP_RB;
          end
          4'h7: begin we <= cmd_frame[0]; perf <= cmd_frame[1]; end
          default: ;
        endcase
      end
    end
  end

  // R14
  slots_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
    slots_used <= UW'(SLOTS));
  // R14
  slots_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (slots_used == $past(slots_used)) || (slots_used == $past(slots_used) + 1'b1));
  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (acc && code == 4'h1 && !we) |=> $stable(wiper));
  // R9
  full_refuse_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (acc && code == 4'h3 && slots_used == UW'(SLOTS)) |=> !busy);
  // R11
  reset_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> busy);
endmodule

// File: tb/trim_store_ctrl_tb.sv
`timescale 1ns/1ps
module trim_store_ctrl_tb;
  localparam int DW = 10, NS = 50, PW = 40, RS = 12, PG = 20;
  localparam int RB = 6, WR = 2, WP = 8, GP = 4;
  localparam int UW = $clog2(NS + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n, rst_n, cmd_valid;
  logic [15:0] cmd_frame;
  logic [DW-1:0] wiper, rd_data;
  logic busy, rd_valid;
  logic [UW-1:0] slots_used;

  trim_store_ctrl #(.DATA_W(DW), .SLOTS(NS), .PWR_CYC(PW), .RST_CYC(RS),
    .PROG_CYC(PG), .RDBK_CYC(RB), .WR_CYC(WR), .WRP_CYC(WP), .GAP_CYC(GP)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_frame(cmd_frame), .wiper(wiper), .busy(busy), .slots_used(slots_used),
    .rd_data(rd_data), .rd_valid(rd_valid));

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic [15:0] fr(input [3:0] c, input [9:0] d);
    return {2'b00, c, d};
  endfunction

  task automatic send(input [15:0] f);
    @(negedge clk); cmd_valid = 1'b1; cmd_frame = f;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
    repeat (GP) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_power();
    int n;
    por_n = 1'b0; rst_n = 1'b1; cmd_valid = 1'b0; cmd_frame = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    check("R2 busy at release", busy, 1);
    busy_len(n);
    check("R2 power window", n, PW);
    check("R2 midscale", wiper, 'h200);
    check("R2 blank bank", slots_used, 0);
    check("R5 rd_valid low", rd_valid, 0);
  endtask

  task automatic t_locked();
    send(fr(4'h1, 10'h155));
    check("R3 locked write wiper", wiper, 'h200);
    check("R3 locked write busy", busy, 0);
    idle();
  endtask

  task automatic t_write();
    int n;
    send(fr(4'h7, 10'h001)); idle();
    send(fr(4'h1, 10'h155));
    check("R4 write value", wiper, 'h155);
    busy_len(n); check("R4 normal window", n, WR);
    idle();
    send(fr(4'h7, 10'h003)); idle();
    send(fr(4'h1, 10'h0AA));
    check("R4 perf write value", wiper, 'h0AA);
    busy_len(n); check("R4 perf window", n, WP);
    idle();
    send(fr(4'h7, 10'h001)); idle();
  endtask

  task automatic t_read();
    send(fr(4'h2, 10'h000));
    check("R5 rd_valid", rd_valid, 1);
    check("R5 rd_data", rd_data, 'h0AA);
    idle();
    send(fr(4'h6, 10'h3FF));
    check("R5 rd_valid cleared", rd_valid, 0);
    check("R13 noop wiper", wiper, 'h0AA);
    check("R13 noop busy", busy, 0);
    idle();
    send({2'b01, 4'h1, 10'h3FF});
    check("R1 bad lead bits", wiper, 'h0AA);
    idle();
  endtask

  task automatic t_gap();
    send(fr(4'h1, 10'h111));
    cmd_valid = 1'b1; cmd_frame = fr(4'h1, 10'h222);
    repeat (3) @(negedge clk);
    check("R7 early frame ignored", wiper, 'h111);
    @(negedge clk); cmd_valid = 1'b0;
    check("R7 frame at gap end", wiper, 'h222);
    idle();
  endtask

  task automatic t_store();
    int n;
    send(fr(4'h1, 10'h0AA)); idle();
    send(fr(4'h3, 10'h000));
    check("R8 store busy", busy, 1);
    check("R8 count before end", slots_used, 0);
    repeat (PG - 2) @(negedge clk);
    cmd_valid = 1'b1; cmd_frame = fr(4'h1, 10'h3FF);
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 busy falls", busy, 0);
    check("R8 count at end", slots_used, 1);
    check("R6 write during window", wiper, 'h0AA);
    idle();
    send(fr(4'h1, 10'h123)); idle();
    send(fr(4'h4, 10'h000));
    busy_len(n); check("R10 restore window", n, RS);
    check("R10 restored value", wiper, 'h0AA);
    idle();
  endtask

  task automatic t_slot_rb();
    int n;
    send(fr(4'h5, 10'd0));
    busy_len(n); check("R12 readback window", n, RB);
    check("R12 rd_valid", rd_valid, 1);
    check("R12 slot 0", rd_data, 'h0AA);
    idle();
    send(fr(4'h5, 10'd10));
    busy_len(n);
    check("R12 blank slot", rd_data, 0);
    idle();
  endtask

  task automatic t_reset();
    int n;
    send(fr(4'h1, 10'h321)); idle();
    check("R4 before reset", wiper, 'h321);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    busy_len(n); check("R11 reset window", n, RS);
    check("R11 reset restore", wiper, 'h0AA);
    check("R11 slots kept", slots_used, 1);
    idle();
    send(fr(4'h1, 10'h050));
    check("R11 enable cleared", wiper, 'h0AA);
    idle();
    send(fr(4'h7, 10'h001)); idle();
    send(fr(4'h3, 10'h000));
    repeat (5) @(negedge clk);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    idle();
    check("R11 aborted store", slots_used, 1);
  endtask

  task automatic t_exhaust();
    int n;
    send(fr(4'h7, 10'h001)); idle();
    for (int i = 1; i < NS; i++) begin
      send(fr(4'h1, 10'(10'h100 + i))); idle();
      send(fr(4'h3, 10'h000)); idle();
    end
    check("R14 full count", slots_used, NS);
    send(fr(4'h1, 10'h001)); idle();
    send(fr(4'h3, 10'h000));
    check("R9 refused busy", busy, 0);
    @(negedge clk);
    check("R9 count held", slots_used, NS);
    idle();
    send(fr(4'h4, 10'h000));
    busy_len(n);
    check("R10 latest slot", wiper, 'h131);
    idle();
    send(fr(4'h5, 10'd49));
    busy_len(n);
    check("R12 last slot", rd_data, 'h131);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_power();
    t_locked();
    t_write();
    t_read();
    t_gap();
    t_store();
    t_slot_rb();
    t_reset();
    t_exhaust();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end
endmodule